// File: doc/BRIEF.md
# Configurable Serial Shift Engine

This block moves a software-chosen number of bits through a shift register over a synchronous three-wire serial link (clock, data in, data out). Each transfer can be 8 or 16 bits wide and can send either end first. Software writes the outgoing word and then loads a bit count. The engine shifts one bit per serial clock period and counts down. When the count reaches zero it raises a completion flag, and it can also raise an interrupt request.

As a master, the engine makes the serial clock itself. It divides either the system clock or a clock bit that software toggles by a power of two. As a slave, it follows an external serial clock, which it first resynchronises into the system clock domain. Clock polarity and phase are selectable. The data output comes from a latch that updates on the "change" edge, or from a transparent path. A separate enable gates the output. A soft-reset bit parks the engine. The register port is a plain write strobe with a combinational read.

Top module: `shift_engine`

## Requirements
- R1: After reset the control register (address 0) reads 0x0001. Bit 0 is the soft-reset hold. While the hold bit is set, the count and the completion flag are held at zero, the serial clock output sits at its idle level and the output latch holds 0.
- R2: Control bit 3 selects the shift width. With bit 3 = 0, only data bits 7:0 (address 2) shift and bits 15:8 keep their value. With bit 3 = 1, all 16 bits shift as one register.
- R3: Control bit 2 selects the bit order for both transmit and receive. With bit 2 = 0 the top bit of the active width goes out first and received bits enter at bit 0. With bit 2 = 1 bit 0 goes out first and received bits enter at the top of the active width.
- R4: Address 1 bits 4:0 hold the bit count. It drops by one for each captured bit. When it steps from 1 to 0, the completion flag sets. The flag reads at address 1 bit 8 and at address 3 bit 0.
- R5: Writing a nonzero count clears the flag when control bit 9 is 0, and leaves the flag alone when bit 9 is 1. Writing address 3 with bit 0 set always clears the flag.
- R6: While the count is zero, no serial clock edge shifts the register or changes the output latch.
- R7: Control bit 4 is the phase. With bit 4 = 0, the first edge of each bit updates the output latch and the second edge captures data in. With bit 4 = 1, the first edge captures and the second edge updates the latch. Loading a nonzero count also loads the latch with the first outgoing bit.
- R8: Control bit 5 sets the idle level of the serial clock output: 0 means idle low and 1 means idle high.
- R9: In master mode (control bit 1 = 1), the serial clock changes level once every 2^N source events, where N is control bits 12:10. With the system clock as source, one serial period lasts 2^(N+1) system clocks. The clock runs while the count is nonzero and always finishes back at idle.
- R10: When control bit 13 is set, the source events are the rising transitions of software clock bit 14 instead of system clock cycles.
- R11: Control bit 7 = 1 makes the data output follow the outgoing bit directly (transparent). Control bit 7 = 0 drives it from the latch. When control bit 6 is 0, the data output is 0 and the output enable is low.
- R12: In slave mode (control bit 1 = 0), the external serial clock passes through a two-flop synchroniser, and its edges are judged against the polarity bit.
- R13: The interrupt output is high exactly when the completion flag and control bit 8 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count, 2 data, 3 flag clear |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| irq | output | 1 | Completion interrupt request |

## Verification
The assertions assume that registers change only through the write port, with addresses in the 0..3 range, and that the hold bit is a registered control, so its clearing effect shows one cycle after it is written. In slave mode the correctness of the shift also assumes that sclk_in holds each level for at least three system clocks and that sdi is stable when it is sampled. The bench toggles sclk_in only every four cycles. It takes sdi either from the inverted data output or from a constant, and it changes every input at the falling system clock edge.

// File: rtl/se_pkg.sv
package se_pkg;

    localparam int DIV_W       = 3;
    localparam int CTRL_W      = 15;
    localparam int FLAG_RD_BIT = 8;
    localparam logic [CTRL_W-1:0] CTRL_RST = 15'h0001;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_DATA  = 2'd2,
        ADDR_FLAG  = 2'd3
    } se_addr_e;

    typedef struct packed {
        logic             hold;
        logic             master;
        logic             lsb_first;
        logic             wide;
        logic             cpha;
        logic             cpol;
        logic             out_en;
        logic             transparent;
        logic             irq_en;
        logic             keep_flag;
        logic [DIV_W-1:0] div;
        logic             src_sw;
        logic             sw_clk;
    } se_cfg_t;

    function automatic se_cfg_t se_decode(input logic [CTRL_W-1:0] c);
        se_cfg_t f;
        f.hold        = c[0];
        f.master      = c[1];
        f.lsb_first   = c[2];
        f.wide        = c[3];
        f.cpha        = c[4];
        f.cpol        = c[5];
        f.out_en      = c[6];
        f.transparent = c[7];
        f.irq_en      = c[8];
        f.keep_flag   = c[9];
        f.div         = c[12:10];
        f.src_sw      = c[13];
        f.sw_clk      = c[14];
        return f;
    endfunction

endpackage

// File: rtl/se_clkgen.sv
module se_clkgen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             master,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    input  logic             src_sw,
    input  logic             sw_clk,
    input  logic             run,
    input  logic             sclk_in,
    output logic             lead,
    output logic             trail,
    output logic             sclk_out
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             sck;
        logic             swc;
        logic             s1;
        logic             s2;
        logic             prev;
    } clk_st_t;

    clk_st_t q, d;
    logic [PRE_W-1:0] limit;
    logic             src_evt;
    logic             active;
    logic             lvl_now;
    logic             lvl_old;

    always_comb begin
        d       = q;
        lead    = 1'b0;
        trail   = 1'b0;
        limit   = PRE_W'((32'd1 << div) - 32'd1);
        src_evt = src_sw ? (sw_clk & ~q.swc) : 1'b1;
        active  = run | q.sck;
        lvl_now = q.s2 ^ cpol;
        lvl_old = q.prev ^ cpol;
        // synchroniser and software clock history run continuously
        d.swc  = sw_clk;
        d.s1   = sclk_in;
        d.s2   = q.s1;
        d.prev = q.s2;
        if (hold || !master) begin
            d.pre = '0;
            d.sck = 1'b0;
            if (!hold) begin
                lead  = lvl_now & ~lvl_old;
                trail = ~lvl_now & lvl_old;
            end
        end else if (!active) begin
            d.pre = '0;
        end else if (src_evt) begin
            if (q.pre == limit) begin
                d.pre = '0;
                d.sck = ~q.sck;
                lead  = ~q.sck;
                trail = q.sck;
            end else begin
                d.pre = q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_out = (q.sck & master) ^ cpol;

endmodule

// File: rtl/se_shifter.sv
module se_shifter #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              lsb_first,
    input  logic              wide,
    input  logic              cpha,
    input  logic              transparent,
    input  logic              out_en,
    input  logic              keep_flag,
    input  logic              lead,
    input  logic              trail,
    input  logic              sdi,
    input  logic              wr_sr,
    input  logic              wr_cnt,
    input  logic              clr_flag,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sr,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              flag;
        logic              lat;
    } sh_st_t;

    sh_st_t q, d;
    logic              busy;
    logic              capture;
    logic              change;
    logic              tx_bit;
    logic              cnt_load_nz;
    logic [DATA_W-1:0] shifted;
    logic [HALF-1:0]   low_shift;

    assign busy        = (q.cnt != '0);
    assign capture     = busy & (cpha ? lead : trail);
    assign change      = busy & (cpha ? trail : lead);
    assign tx_bit      = lsb_first ? q.sr[0] : (wide ? q.sr[DATA_W-1] : q.sr[HALF-1]);
    assign cnt_load_nz = wr_cnt & (wr_data[CNT_W-1:0] != '0);

    always_comb begin
        low_shift = lsb_first ? {sdi, q.sr[HALF-1:1]} : {q.sr[HALF-2:0], sdi};
        if (wide) begin
            shifted = lsb_first ? {sdi, q.sr[DATA_W-1:1]} : {q.sr[DATA_W-2:0], sdi};
        end else begin
            shifted = {q.sr[DATA_W-1:HALF], low_shift};
        end
    end

    always_comb begin
        d = q;
        if (capture) begin
            d.sr  = shifted;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) d.flag = 1'b1;
        end
        if (change)   d.lat  = tx_bit;
        if (clr_flag) d.flag = 1'b0;
        if (wr_sr)    d.sr   = wr_data;
        if (wr_cnt) begin
            d.cnt = wr_data[CNT_W-1:0];
            if (cnt_load_nz) begin
                d.lat = tx_bit;
                if (!keep_flag) d.flag = 1'b0;
            end
        end
        if (hold) begin
            d.cnt  = '0;
            d.flag = 1'b0;
            d.lat  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sr     = q.sr;
    assign cnt    = q.cnt;
    assign flag   = q.flag;
    assign sdo    = out_en & (transparent ? tx_bit : q.lat);
    assign sdo_oe = out_en;

endmodule

// File: rtl/shift_engine.sv
module shift_engine
    import se_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_st_t;

    top_st_t q, d;
    se_cfg_t cfg;

    logic              wr_ctrl_w;
    logic              wr_cnt_w;
    logic              wr_sr_w;
    logic              clr_flag_w;
    logic              lead_w;
    logic              trail_w;
    logic              run_w;
    logic              hold_w;
    logic              wide_w;
    logic              flag_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] sr_w;

    assign wr_ctrl_w  = wr_en & (se_addr_e'(wr_addr) == ADDR_CTRL);
    assign wr_cnt_w   = wr_en & (se_addr_e'(wr_addr) == ADDR_COUNT);
    assign wr_sr_w    = wr_en & (se_addr_e'(wr_addr) == ADDR_DATA);
    assign clr_flag_w = wr_en & (se_addr_e'(wr_addr) == ADDR_FLAG) & wr_data[0];

    always_comb begin
        d = q;
        if (wr_ctrl_w) d.ctrl = wr_data[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.ctrl <= CTRL_RST;
        else        q      <= d;
    end

    assign cfg    = se_decode(q.ctrl);
    assign hold_w = cfg.hold;
    assign wide_w = cfg.wide;
    assign run_w  = (cnt_w != '0);

    se_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cfg.hold),
        .master   (cfg.master),
        .cpol     (cfg.cpol),
        .div      (cfg.div),
        .src_sw   (cfg.src_sw),
        .sw_clk   (cfg.sw_clk),
        .run      (run_w),
        .sclk_in  (sclk_in),
        .lead     (lead_w),
        .trail    (trail_w),
        .sclk_out (sclk_out)
    );

    se_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (cfg.hold),
        .lsb_first   (cfg.lsb_first),
        .wide        (cfg.wide),
        .cpha        (cfg.cpha),
        .transparent (cfg.transparent),
        .out_en      (cfg.out_en),
        .keep_flag   (cfg.keep_flag),
        .lead        (lead_w),
        .trail       (trail_w),
        .sdi         (sdi),
        .wr_sr       (wr_sr_w),
        .wr_cnt      (wr_cnt_w),
        .clr_flag    (clr_flag_w),
        .wr_data     (wr_data),
        .sr          (sr_w),
        .cnt         (cnt_w),
        .flag        (flag_w),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

    always_comb begin
        rd_data = '0;
        case (se_addr_e'(rd_addr))
            ADDR_CTRL:  rd_data[CTRL_W-1:0] = q.ctrl;
            ADDR_COUNT: begin
                rd_data[CNT_W-1:0]   = cnt_w;
                rd_data[FLAG_RD_BIT] = flag_w;
            end
            ADDR_DATA:  rd_data = sr_w;
            ADDR_FLAG:  rd_data[0] = flag_w;
            default:    rd_data = '0;
        endcase
    end

    assign irq = flag_w & cfg.irq_en;

endmodule

// File: rtl/se_checker.sv
module se_checker #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              wide,
    input logic              wr_cnt,
    input logic              wr_sr,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic [DATA_W-1:0] sr
);
    localparam int HALF = DATA_W / 2;

    // R1: a registered hold empties count and flag on the next cycle
    a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0 && !flag));

    // R4: without a load the count moves by at most one step down
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !wr_cnt && !hold) |=>
            (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

    // R4: the flag only rises together with an empty count
    a_r4_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && !$past(wr_cnt)) |-> (cnt == '0));

    // R6: an empty count freezes the shift register
    a_r6_frozen_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !wr_sr) |=> (sr == $past(sr)));

    // R2: narrow mode never touches the upper half
    a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !wr_sr) |=> (sr[DATA_W-1:HALF] == $past(sr[DATA_W-1:HALF])));

endmodule

bind shift_engine se_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold_w),
    .wide   (wide_w),
    .wr_cnt (wr_cnt_w),
    .wr_sr  (wr_sr_w),
    .cnt    (cnt_w),
    .flag   (flag_w),
    .sr     (sr_w)
);

// File: tb/shift_engine_test.sv
module shift_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic        sclk_in = 1'b0;
    logic        loop_mode = 1'b1;
    logic        sdi_const = 1'b0;
    wire  [15:0] rd_data;
    wire         sclk_out, sdo, sdo_oe, irq;
    wire         sdi = loop_mode ? ~sdo : sdi_const;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    shift_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sdi(sdi), .sdo(sdo),
        .sdo_oe(sdo_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [14:0] m_ctrl;
    bit [15:0] m_sr;
    int        m_cnt, m_pre;
    bit        m_flag, m_lat, m_sck, m_swc, m_s1, m_s2, m_prev;

    function automatic bit m_tx();
        if (m_ctrl[2]) return m_sr[0];
        return m_ctrl[3] ? m_sr[15] : m_sr[7];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 15'h0001; m_sr = 0; m_cnt = 0; m_pre = 0;
            m_flag = 0; m_lat = 0; m_sck = 0; m_swc = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            bit hold, mst, cpol, cpha, ld, tr, cap, chg, n_flag, n_lat, n_sck, ev, tx;
            bit [14:0] n_ctrl;
            bit [15:0] n_sr;
            int n_cnt, n_pre, div;
            hold = m_ctrl[0]; mst = m_ctrl[1]; cpha = m_ctrl[4]; cpol = m_ctrl[5];
            div = int'(m_ctrl[12:10]);
            ld = 0; tr = 0; n_pre = m_pre; n_sck = m_sck;
            if (!hold && mst) begin
                if (m_cnt != 0 || m_sck) begin
                    ev = m_ctrl[13] ? (m_ctrl[14] && !m_swc) : 1'b1;
                    if (ev) begin
                        if (m_pre == (1 << div) - 1) begin
                            n_pre = 0; n_sck = !m_sck;
                            if (m_sck) tr = 1; else ld = 1;
                        end else n_pre = m_pre + 1;
                    end
                end else n_pre = 0;
            end else begin
                n_pre = 0; n_sck = 0;
                if (!hold) begin
                    ld = (m_s2 ^ cpol) && !(m_prev ^ cpol);
                    tr = !(m_s2 ^ cpol) && (m_prev ^ cpol);
                end
            end
            tx = m_tx();
            cap = (m_cnt != 0) && (cpha ? ld : tr);
            chg = (m_cnt != 0) && (cpha ? tr : ld);
            n_sr = m_sr; n_cnt = m_cnt; n_flag = m_flag; n_lat = m_lat; n_ctrl = m_ctrl;
            if (cap) begin
                if (m_ctrl[3]) n_sr = m_ctrl[2] ? {sdi, m_sr[15:1]} : {m_sr[14:0], sdi};
                else n_sr[7:0] = m_ctrl[2] ? {sdi, m_sr[7:1]} : {m_sr[6:0], sdi};
                n_cnt = m_cnt - 1;
                if (m_cnt == 1) n_flag = 1;
            end
            if (chg) n_lat = tx;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: n_ctrl = wr_data[14:0];
                    2'd1: begin
                        n_cnt = int'(wr_data[4:0]);
                        if (wr_data[4:0] != 0) begin
                            n_lat = tx;
                            if (!m_ctrl[9]) n_flag = 0;
                        end
                    end
                    2'd2: n_sr = wr_data;
                    default: if (wr_data[0]) n_flag = 0;
                endcase
            end
            if (hold) begin n_cnt = 0; n_flag = 0; n_lat = 0; end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = sclk_in; m_swc = m_ctrl[14];
            m_ctrl = n_ctrl; m_sr = n_sr; m_cnt = n_cnt; m_flag = n_flag;
            m_lat = n_lat; m_pre = n_pre; m_sck = n_sck;
        end
    end

    // compare ports with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_sdo;
            e_sdo = m_ctrl[6] && (m_ctrl[7] ? m_tx() : m_lat);
            check("R9 model sclk_out", sclk_out, (m_sck && m_ctrl[1]) ^ m_ctrl[5]);
            check("R11 model sdo", sdo, e_sdo);
            check("R11 model sdo_oe", sdo_oe, m_ctrl[6]);
            check("R13 model irq", irq, m_flag && m_ctrl[8]);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [15:0] mk(bit hold, bit mst, bit lsb, bit wide, bit cpha,
                                       bit cpol, bit oe, bit transp, bit ie, bit keep,
                                       int div, bit src, bit sw);
        logic [15:0] v;
        v = '0;
        v[0] = hold; v[1] = mst; v[2] = lsb; v[3] = wide; v[4] = cpha; v[5] = cpol;
        v[6] = oe; v[7] = transp; v[8] = ie; v[9] = keep; v[12:10] = 3'(div);
        v[13] = src; v[14] = sw;
        return v;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_flag();
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(2'd3, v);
            if (v[0]) break;
        end
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int cyc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(2'd0, v); check("R1 control reset value", v, 16'h0001);
        rd(2'd1, v); check("R1 count zero after reset", v, 16'h0000);
        check("R1 idle clock after reset", sclk_out, 1'b0);
        check("R13 irq low after reset", irq, 1'b0);

        // output path: transparent, latched, disabled
        wr(2'd0, mk(1,0,0,0,0,0,1,1,0,0,0,0,0));
        wr(2'd2, 16'h0080);
        check("R11 transparent follows top bit", sdo, 1'b1);
        wr(2'd2, 16'h0000);
        check("R11 transparent follows zero", sdo, 1'b0);
        wr(2'd0, mk(1,0,0,0,0,0,1,0,0,0,0,0,0));
        wr(2'd2, 16'h0080);
        check("R11 latched output ignores new word", sdo, 1'b0);
        wr(2'd0, mk(1,0,0,0,0,0,0,1,0,0,0,0,0));
        check("R11 disabled output low", sdo, 1'b0);
        check("R11 disabled output enable low", sdo_oe, 1'b0);

        // master, 8-bit, top bit first, phase 0, inverted loopback
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,0,0,0));
        wr(2'd2, 16'hBEA5);
        wr(2'd1, 16'd8);
        wait_flag();
        rd(2'd2, v); check("R2 R3 R7 narrow top-first result", v, 16'hBE5A);
        rd(2'd1, v); check("R4 count empty and flag at bit 8", v, 16'h0100);
        repeat (20) @(negedge clk);
        rd(2'd2, v); check("R6 word frozen after completion", v, 16'hBE5A);
        check("R8 idle low after transfer", sclk_out, 1'b0);

        // wide, bit 0 first, phase 1, idle high, divide by 2
        wr(2'd0, mk(0,1,1,1,1,1,1,0,0,0,1,0,0));
        check("R8 idle high level", sclk_out, 1'b1);
        wr(2'd2, 16'h1234);
        wr(2'd1, 16'd16);
        wait_flag();
        rd(2'd2, v); check("R2 R3 R7 wide bit0-first result", v, 16'hEDCB);

        // partial count of 4
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,0,0,0));
        wr(2'd2, 16'h0096);
        wr(2'd1, 16'd4);
        rd(2'd3, v); check("R5 nonzero load clears flag", v, 16'h0000);
        wait_flag();
        rd(2'd2, v); check("R4 four-bit partial transfer", v, 16'h0066);

        // flag kept on reload when bit 9 is set
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,1,0,0,0));
        wr(2'd1, 16'd2);
        rd(2'd3, v); check("R5 flag kept on reload", v, 16'h0001);
        repeat (10) @(negedge clk);
        wr(2'd3, 16'h0001);
        rd(2'd3, v); check("R5 explicit clear", v, 16'h0000);

        // interrupt
        wr(2'd0, mk(0,1,0,0,0,0,1,0,1,0,0,0,0));
        wr(2'd1, 16'd1);
        wait_flag();
        @(negedge clk);
        check("R13 irq with flag and enable", irq, 1'b1);
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,0,0,0));
        check("R13 irq masked", irq, 1'b0);

        // divider period
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,3,0,0));
        wr(2'd1, 16'd2);
        cyc = 0;
        while (sclk_out !== 1'b1) @(negedge clk);
        while (sclk_out === 1'b1) begin @(negedge clk); cyc++; end
        while (sclk_out === 1'b0) begin @(negedge clk); cyc++; end
        check("R9 divide-by-8 serial period", cyc, 16);
        wait_flag();

        // software clock source
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,0,1,0));
        wr(2'd1, 16'd1);
        repeat (5) @(negedge clk);
        check("R10 no software edge no clock", sclk_out, 1'b0);
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,0,1,1));
        @(negedge clk);
        check("R10 software rise raises clock", sclk_out, 1'b1);
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,0,1,0));
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,0,1,1));
        @(negedge clk);
        check("R10 second rise returns clock", sclk_out, 1'b0);
        rd(2'd3, v); check("R10 one-bit transfer completes", v, 16'h0001);

        // hold during a slow transfer
        wr(2'd0, mk(0,1,0,0,0,0,1,0,0,0,7,0,0));
        wr(2'd1, 16'd8);
        repeat (300) @(negedge clk);
        wr(2'd0, mk(1,1,0,0,0,0,1,0,0,0,7,0,0));
        @(negedge clk);
        rd(2'd1, v); check("R1 hold clears count and flag", v, 16'h0000);
        check("R1 hold parks clock", sclk_out, 1'b0);

        // slave mode, idle high, phase 0
        sclk_in = 1'b1;
        wr(2'd0, mk(1,0,0,0,0,1,1,0,0,0,0,0,0));
        repeat (5) @(negedge clk);
        wr(2'd0, mk(0,0,0,0,0,1,1,0,0,0,0,0,0));
        wr(2'd2, 16'h003C);
        wr(2'd1, 16'd8);
        for (int i = 0; i < 16; i++) begin
            repeat (4) @(negedge clk);
            sclk_in = ~sclk_in;
        end
        repeat (6) @(negedge clk);
        rd(2'd2, v); check("R12 slave transfer result", v, 16'h00C3);
        for (int i = 0; i < 4; i++) begin
            repeat (4) @(negedge clk);
            sclk_in = ~sclk_in;
        end
        repeat (6) @(negedge clk);
        rd(2'd2, v); check("R6 extra slave edges ignored", v, 16'h00C3);

        // disabled output while shifting
        wr(2'd0, mk(0,1,0,0,0,0,0,0,0,0,0,0,0));
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'd8);
        check("R11 output enable low while shifting", sdo_oe, 1'b0);
        wait_flag();
        rd(2'd2, v); check("R11 gated output shifts in ones", v, 16'h00FF);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule